// File: doc/BRIEF.md
# Converter Channel-Select Register with Deferred Commit

This block is the 8-bit control register that sits between a system bus and an analog converter front end. Software writes a reference choice, an input channel and a result-alignment flag into one byte. The byte always lands first in a staging copy. The reference and channel values that actually steer the analog side are copied from that staging copy only at safe moments. A safe moment is any cycle in which no conversion is running, or the cycle in which the running conversion reports completion. The alignment flag is not deferred. It reshapes the presented result at once.

A small state machine tracks whether a conversion is in flight. It has two states:
- `ST_IDLE`: no conversion is running. Transition `T_START` goes to `ST_CONV` when `conv_busy` is sampled high.
- `ST_CONV`: a conversion is running. Transition `T_FINISH` goes back to `ST_IDLE` when `conv_done` is sampled high.

The 10-bit conversion code runs from 0x000 (ground) to 0x3FF (reference minus one LSB). The block presents it as two readable bytes, either right-adjusted or left-adjusted.

Top module: `adc_ctrl_reg`

## Requirements
- R1: After reset, the control byte reads 0x00 and `ref_sel` and `chan_sel` are both 0.
- R2: Reading address 0 returns the staged control byte. Bits 7:6 hold the reference code, bit 5 holds the left-adjust flag (1 = left), and bits 3:0 hold the channel code. Bit 4 always reads 0, even after a write of 1 to it.
- R3: In a cycle where the machine is in `ST_IDLE` and `conv_busy` is low, a write to address 0 drives `ref_sel` (bits 7:6) and `chan_sel` (bits 3:0) from the written byte after that clock edge.
- R4: Transition `T_START` is taken when `conv_busy` is high in `ST_IDLE`. From that cycle until the cycle `conv_done` is high, `ref_sel` and `chan_sel` keep their values, whatever is written.
- R5: At the edge where `conv_done` is high, `ref_sel` and `chan_sel` take the staged fields, including a write made in that same cycle. With several writes during one conversion, the last one is committed.
- R6: A write that changes the left-adjust bit changes the result bytes read at addresses 1 and 2 right after that edge, even in `ST_CONV`.
- R7: With left-adjust 0, address 1 reads result bits 7:0 and address 2 reads result bits 9:8 in its bits 1:0, with zeros above.
- R8: With left-adjust 1, address 2 reads result bits 9:2 and address 1 reads result bits 1:0 in its bits 7:6, with zeros below.
- R9: Address 3 always reads 0x00.
- R10: Reference codes are passed to `ref_sel` unchanged: 00 for the external reference pin, 01 for the analog supply, 10 reserved, 11 for the internal 2.56 V reference. Channel codes 0000 to 0101 select single-ended inputs 0 to 5 and are passed unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | Bus write address |
| wr_data | input | 8 | Bus write data |
| rd_addr | input | 2 | Bus read address |
| rd_data | output | 8 | Bus read data, combinational |
| conv_busy | input | 1 | Converter reports a conversion is running |
| conv_done | input | 1 | Converter reports the conversion completed this cycle |
| conv_result | input | 10 | Latest conversion code |
| ref_sel | output | 2 | Active reference selection |
| chan_sel | output | 4 | Active channel selection |

## Verification
Directed patterns come first. These are an idle write (immediate commit), a write of the reserved reference code, and a series of writes inside one conversion (held, then last-wins at completion). A done pulse with a same-cycle write tells whether the staged value or the write is committed. An alignment flip in mid-conversion tells the immediate path apart from the deferred one. Random traffic then mixes busy starts, done pulses, writes to all addresses and reads of all four addresses against varied result codes. This shows that the deferred and immediate fields never leak into each other.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
    localparam int CTRL_W   = 8;
    localparam int REF_W    = 2;
    localparam int CHAN_W   = 4;
    localparam int REF_LSB  = 6;
    localparam int ALIGN_B  = 5;
    localparam int SPARE_B  = 4;
    localparam int CHAN_LSB = 0;
    localparam logic [CTRL_W-1:0] WR_MASK = ~(CTRL_W'(1) << SPARE_B);

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } conv_state_t;
endpackage

// File: rtl/adc_ctrl_stage.sv
module adc_ctrl_stage
    import adc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] stage_q,
    output logic [CTRL_W-1:0] stage_nxt
);
    always_comb begin
        stage_nxt = wr_hit ? (wr_data & WR_MASK) : stage_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_nxt;
    end

    // R2: the spare position never holds a one
    p_spare_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stage_q[SPARE_B] == 1'b0);

    // R6: a write lands in the staging copy on the next edge
    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> stage_q[ALIGN_B] == $past(wr_data[ALIGN_B]));
endmodule

// File: rtl/adc_ctrl_commit.sv
module adc_ctrl_commit
    import adc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_busy,
    input  logic              conv_done,
    input  logic [CTRL_W-1:0] stage_nxt,
    output logic [REF_W-1:0]  ref_sel,
    output logic [CHAN_W-1:0] chan_sel
);
    conv_state_t state_q, state_d;
    logic        commit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (conv_busy) state_d = ST_CONV;   // T_START
            ST_CONV: if (conv_done) state_d = ST_IDLE;   // T_FINISH
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        commit = conv_done || (state_q == ST_IDLE && !conv_busy);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_sel  <= '0;
            chan_sel <= '0;
        end else if (commit) begin
            ref_sel  <= stage_nxt[REF_LSB +: REF_W];
            chan_sel <= stage_nxt[CHAN_LSB +: CHAN_W];
        end
    end

    // R4: active fields frozen while a conversion runs
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && !conv_done) |=> ($stable(ref_sel) && $stable(chan_sel)));

    // R3: idle, not starting -> staged fields appear next edge
    p_idle_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !conv_busy) |=>
            (ref_sel == $past(stage_nxt[REF_LSB +: REF_W]) &&
             chan_sel == $past(stage_nxt[CHAN_LSB +: CHAN_W])));

    // R5: completion commits the latest staged fields
    p_done_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> (ref_sel == $past(stage_nxt[REF_LSB +: REF_W]) &&
                       chan_sel == $past(stage_nxt[CHAN_LSB +: CHAN_W])));

    // R4: start leaves idle
    p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && conv_busy) |=> state_q == ST_CONV);
endmodule

// File: rtl/adc_res_fmt.sv
module adc_res_fmt #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic [RES_W-1:0]  result,
    input  logic              left_adj,
    output logic [BYTE_W-1:0] lo_byte,
    output logic [BYTE_W-1:0] hi_byte
);
    localparam int PAIR_W = 2 * BYTE_W;
    localparam int PAD_W  = PAIR_W - RES_W;

    logic [PAIR_W-1:0] packed_res;

    always_comb begin
        if (left_adj) packed_res = {result, {PAD_W{1'b0}}};
        else          packed_res = {{PAD_W{1'b0}}, result};
        lo_byte = packed_res[BYTE_W-1:0];
        hi_byte = packed_res[PAIR_W-1:BYTE_W];
    end

    // R7: right-adjusted high byte is zero-padded at the top
    always_comb begin
        if (!left_adj) p_right_pad_r7: assert (hi_byte[BYTE_W-1:RES_W-BYTE_W] == '0);
    end

    // R8: left-adjusted low byte is zero-padded at the bottom
    always_comb begin
        if (left_adj) p_left_pad_r8: assert (lo_byte[PAD_W-1:0] == '0);
    end
endmodule

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
    import adc_ctrl_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              conv_busy,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    output logic [REF_W-1:0]  ref_sel,
    output logic [CHAN_W-1:0] chan_sel
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(2);

    logic              wr_hit;
    logic [CTRL_W-1:0] stage_q;
    logic [CTRL_W-1:0] stage_nxt;
    logic [CTRL_W-1:0] lo_byte;
    logic [CTRL_W-1:0] hi_byte;

    assign wr_hit = wr_en && (wr_addr == A_CTRL);

    adc_ctrl_stage u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_hit),
        .wr_data  (wr_data),
        .stage_q  (stage_q),
        .stage_nxt(stage_nxt)
    );

    adc_ctrl_commit u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .conv_busy(conv_busy),
        .conv_done(conv_done),
        .stage_nxt(stage_nxt),
        .ref_sel  (ref_sel),
        .chan_sel (chan_sel)
    );

    adc_res_fmt #(.RES_W(RES_W), .BYTE_W(CTRL_W)) u_fmt (
        .result  (conv_result),
        .left_adj(stage_q[ALIGN_B]),
        .lo_byte (lo_byte),
        .hi_byte (hi_byte)
    );

    always_comb begin
        if (rd_addr == A_CTRL)    rd_data = stage_q;
        else if (rd_addr == A_LO) rd_data = lo_byte;
        else if (rd_addr == A_HI) rd_data = hi_byte;
        else                      rd_data = '0;
    end

    // R9: the unused address reads zero
    p_spare_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(3)) |-> rd_data == '0);
endmodule

// File: tb/test_adc_ctrl_reg.sv
module test_adc_ctrl_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       conv_busy = 1'b0;
    logic       conv_done = 1'b0;
    logic [9:0] conv_result = '0;
    logic [1:0] ref_sel;
    logic [3:0] chan_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] m_stage = '0;
    logic [1:0] m_ref = '0;
    logic [3:0] m_chan = '0;
    bit         m_conv = 1'b0;

    always #4 clk = ~clk;

    adc_ctrl_reg i_adc_ctrl_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .conv_busy(conv_busy), .conv_done(conv_done),
        .conv_result(conv_result), .ref_sel(ref_sel), .chan_sel(chan_sel)
    );

    function automatic logic [7:0] exp_read(input logic [1:0] a, input logic [7:0] st,
                                            input logic [9:0] r);
        case (a)
            2'd0: return st;
            2'd1: return st[5] ? {r[1:0], 6'b0} : r[7:0];
            2'd2: return st[5] ? r[9:2] : {6'b0, r[9:8]};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit w, input logic [1:0] wa,
                        input logic [7:0] d, input logic [1:0] ra, input bit b,
                        input bit dn, input logic [9:0] res);
        logic [7:0] nxt;
        bit cmt;
        @(negedge clk);
        wr_en = w; wr_addr = wa; wr_data = d; rd_addr = ra;
        conv_busy = b; conv_done = dn; conv_result = res;
        @(posedge clk);
        nxt = (w && wa == 2'd0) ? (d & 8'hEF) : m_stage;
        cmt = dn || (!m_conv && !b);
        if (cmt) begin
            m_ref = nxt[7:6];
            m_chan = nxt[3:0];
        end
        if (!m_conv) m_conv = b;
        else         m_conv = !dn;
        m_stage = nxt;
        #2;
        chk({tag, " ref_sel"}, ref_sel, m_ref);
        chk({tag, " chan_sel"}, chan_sel, m_chan);
        chk({tag, " rd_data"}, rd_data, exp_read(ra, m_stage, res));
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #2;
        chk("R1 ctrl", rd_data, 8'h00);
        chk("R1 ref_sel", ref_sel, 0);
        chk("R1 chan_sel", chan_sel, 0);
        @(negedge clk); rst_n = 1'b1;

        // R3, R2: idle write commits at once; bit 4 drops
        step("R3", 1, 2'd0, 8'h41, 2'd0, 0, 0, 10'h000);
        step("R2", 1, 2'd0, 8'hFF, 2'd0, 0, 0, 10'h000);
        chk("R2 spare bit", rd_data[4], 0);
        // R10: reserved reference and top channel passed through
        step("R10", 1, 2'd0, 8'h85, 2'd0, 0, 0, 10'h000);
        chk("R10 ref code", ref_sel, 2);
        chk("R10 chan code", chan_sel, 5);
        // R4: start, then writes held
        step("R4", 0, 2'd0, 8'h00, 2'd0, 1, 0, 10'h000);
        step("R4", 1, 2'd0, 8'hC5, 2'd0, 1, 0, 10'h000);
        chk("R4 held ref", ref_sel, 2);
        step("R4", 1, 2'd0, 8'h03, 2'd0, 0, 0, 10'h000);
        chk("R4 held chan", chan_sel, 5);
        // R5: done with a same-cycle write: that write wins
        step("R5", 1, 2'd0, 8'h42, 2'd0, 1, 1, 10'h000);
        chk("R5 commit ref", ref_sel, 1);
        chk("R5 commit chan", chan_sel, 2);
        // R6, R7, R8: alignment flips mid-conversion
        step("R7", 0, 2'd0, 8'h00, 2'd1, 1, 0, 10'h2D7);
        chk("R7 low byte", rd_data, 8'hD7);
        step("R7", 0, 2'd0, 8'h00, 2'd2, 1, 0, 10'h2D7);
        chk("R7 high byte", rd_data, 8'h02);
        step("R6", 1, 2'd0, 8'h20, 2'd2, 1, 0, 10'h2D7);
        chk("R6 R8 high byte", rd_data, 8'hB5);
        chk("R6 ref still held", ref_sel, 1);
        step("R8", 0, 2'd0, 8'h00, 2'd1, 1, 0, 10'h2D7);
        chk("R8 low byte", rd_data, 8'hC0);
        step("R9", 1, 2'd3, 8'hFF, 2'd3, 0, 1, 10'h3FF);
        chk("R9 spare addr", rd_data, 0);

        for (int i = 0; i < 600; i++) begin
            bit b, dn, w;
            b  = !m_conv ? ($urandom % 4 == 0) : ($urandom % 2 == 0);
            dn = m_conv ? ($urandom % 6 == 0) : ($urandom % 20 == 0);
            w  = ($urandom % 2 == 0);
            step("R3/R4/R5/R6/R7/R8/R9/R10 random", w, 2'($urandom % 4),
                 8'($urandom), 2'($urandom % 4), b, dn, 10'($urandom));
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule